// File: doc/BRIEF.md
# Prioritised nested interrupt controller

This block decides when a small processor core leaves its instruction stream for a handler. Software traps, synchronous faults and four external event lines are merged into one request path. Every source has a fixed kind code, and that code is both its priority and its handler vector. The controller is in one of three states: off, armed, or servicing a kind. While it services a kind, a higher kind may preempt it. The preempted kind is recorded as one bit in a mask, and a return from the handler resumes the highest recorded kind.

On every accepted entry the block raises `take_o` in the same cycle as the request. With it, the block presents the vector and the word the core must push. The core performs all stack traffic itself. External events are latched into a pending register and are considered only on the instruction-start strobe. A fault raised while interrupts are off is fatal and sets a sticky halt flag.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Kind codes are 1 external, 2 software trap, 3 divide by zero, 4 bad load/store, 5 unsupported opcode and 6 illegal opcode, and a larger code has higher priority. When `take_o` is high, `vector_o` equals the kind. `entry_word_o` is then {push count[3:0], `ret_pc_i`[27:0]}, with push counts 1, 0, 2, 3, 3, 1 for kinds 1 to 6.
- R2: In the armed state (`state_o`=1), an exception request is taken at once. On the next cycle `state_o`=2 (servicing), `cur_kind_o` holds the kind and `preempt_o` is zero.
- R3: While servicing, a request of higher kind is taken. It sets `preempt_o`[old kind] and becomes the current kind.
- R4: While servicing, a request of lower or equal kind is dropped: `take_o` stays low, and the state, current kind and preempt mask are unchanged.
- R5: A return while servicing goes to the armed state if the preempt mask is empty. Otherwise the highest set bit becomes the current kind and is cleared from the mask. A return outside the servicing state has no effect.
- R6: A return while servicing kind 1 clears every pending external bit and forces the armed state.
- R7: An exception request while off (`state_o`=0) is not taken and sets `halt_o`, which stays high until reset.
- R8: The external bits are 0 keyboard, 1 mouse click, 2 mouse move and 3 vertical sync. They are sampled only on `insn_start_i`, in the armed state, and with no other event in that cycle. If every pending bit is enabled in the mask, kind 1 is taken and `ext_arg_o` gives the index of the highest pending bit.
- R9: If a sampled pending bit is not enabled in the mask, all pending bits are discarded and nothing is taken.
- R10: `dint_i` clears the enable mask and the pending bits and enters the off state. `eint_i` moves off to armed and has no effect in any other state.
- R11: After reset the state is off, and the pending bits, enable mask and halt flag are zero.
- R12: Events in one cycle are resolved in this order: disable, return, exception, enable, external sample. A clear of the pending bits wins over a new pending set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_start_i | input | 1 | Instruction boundary strobe |
| exc_valid_i | input | 1 | Exception or trap request |
| exc_kind_i | input | 3 | Kind of the request (2 to 6) |
| ext_set_i | input | 4 | External event pulses, one per source |
| mask_we_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 4 | Enable mask write data |
| eint_i | input | 1 | Enable-interrupts strobe |
| dint_i | input | 1 | Disable-interrupts strobe |
| reti_i | input | 1 | Return-from-handler strobe |
| ret_pc_i | input | 28 | Return address to be stacked |
| take_o | output | 1 | Entry accepted this cycle |
| vector_o | output | 3 | Handler vector (kind code) |
| entry_word_o | output | 32 | Push count and return address |
| ext_arg_o | output | 2 | Index of the highest pending external bit |
| halt_o | output | 1 | Fatal fault flag |
| state_o | output | 2 | 0 off, 1 armed, 2 servicing |
| cur_kind_o | output | 3 | Kind being serviced |
| preempt_o | output | 7 | Preempted kinds, bit index = kind |
| pend_o | output | 4 | Pending external bits |
| mask_o | output | 4 | External enable mask |

## Verification
The hardest state to reach is a deep nest that unwinds through several returns. Reaching it needs an ascending chain of kinds, and one of those kinds must be the external kind 1, which enters only when all pending bits are enabled. Popping that chain back to kind 1 must then also clear the pending register. A directed prologue builds such a chain on purpose, including simultaneous strobes. After it, a seeded random phase biases the enable strobe while off and keeps the mask mostly full, so that nests and discards both keep occurring. Every cycle is compared against a bench reference model.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int KIND_W = 3;
  localparam int NUM_KINDS = 7;
  localparam int EXT_W = 4;
  localparam int PC_W = 28;
  localparam int CNT_W = 4;
  localparam logic [KIND_W-1:0] KIND_EXT = 3'd1;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_SERVE = 2'd2
  } irq_state_e;

  // registers the core stacks before entering each kind
  function automatic logic [CNT_W-1:0] push_cnt(input logic [KIND_W-1:0] k);
    case (k)
      3'd1: push_cnt = 4'd1;
      3'd3: push_cnt = 4'd2;
      3'd4, 3'd5: push_cnt = 4'd3;
      3'd6: push_cnt = 4'd1;
      default: push_cnt = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_ext_arb.sv
module irq_ext_arb #(
  parameter int EXT_W = 4,
  parameter int ARG_W = $clog2(EXT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXT_W-1:0] set_i,
  input  logic             mask_we_i,
  input  logic [EXT_W-1:0] mask_wd_i,
  input  logic             mask_clr_i,
  input  logic             pend_clr_i,
  input  logic             sample_i,
  output logic             req_o,
  output logic [ARG_W-1:0] arg_o,
  output logic [EXT_W-1:0] pend_o,
  output logic [EXT_W-1:0] mask_o
);
  logic [EXT_W-1:0] pend_q, mask_q;
  logic hit, stray, discard;

  assign hit     = sample_i && (pend_q != '0);
  assign stray   = |(pend_q & ~mask_q);
  assign req_o   = hit && !stray;
  assign discard = hit && stray;

  always_comb begin
    arg_o = '0;
    for (int i = 0; i < EXT_W; i++)
      if (pend_q[i]) arg_o = ARG_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      // clearing wins over a same-cycle set
      if (pend_clr_i || discard) pend_q <= '0;
      else                       pend_q <= pend_q | set_i;
      if (mask_clr_i)     mask_q <= '0;
      else if (mask_we_i) mask_q <= mask_wd_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  p_dint_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_clr_i && pend_clr_i |=> (mask_q == '0) && (pend_q == '0));
  p_discard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && |(pend_q & ~mask_q)) |=> pend_q == '0);
  p_req_keeps_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> pend_q != '0);
endmodule

// File: rtl/irq_prio_fsm.sv
module irq_prio_fsm
  import irq_nest_pkg::*;
#(
  parameter int KW = KIND_W,
  parameter int NK = NUM_KINDS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exc_valid_i,
  input  logic [KW-1:0] exc_kind_i,
  input  logic          ext_req_i,
  input  logic          eint_i,
  input  logic          dint_i,
  input  logic          reti_i,
  output logic          take_o,
  output logic [KW-1:0] vec_o,
  output logic          mmio_ret_o,
  output logic          halt_o,
  output irq_state_e    state_o,
  output logic [KW-1:0] cur_o,
  output logic [NK-1:0] pmask_o
);
  irq_state_e    st_q, st_d;
  logic [KW-1:0] cur_q, cur_d, top_pm;
  logic [NK-1:0] pm_q, pm_d;
  logic          halt_q, halt_d;

  always_comb begin
    top_pm = '0;
    for (int i = 0; i < NK; i++)
      if (pm_q[i]) top_pm = KW'(i);
  end

  always_comb begin
    take_o = 1'b0;
    vec_o  = '0;
    if (!dint_i && !reti_i) begin
      if (exc_valid_i) begin
        if (st_q == ST_ON || (st_q == ST_SERVE && exc_kind_i > cur_q)) begin
          take_o = 1'b1;
          vec_o  = exc_kind_i;
        end
      end else if (ext_req_i) begin
        take_o = 1'b1;
        vec_o  = KIND_EXT;
      end
    end
  end

  always_comb begin
    st_d = st_q; cur_d = cur_q; pm_d = pm_q; halt_d = halt_q;
    mmio_ret_o = 1'b0;
    if (dint_i) begin
      st_d = ST_OFF; cur_d = '0; pm_d = '0;
    end else if (reti_i) begin
      if (st_q == ST_SERVE) begin
        if (cur_q == KIND_EXT || pm_q == '0) begin
          st_d = ST_ON; pm_d = '0;
          mmio_ret_o = (cur_q == KIND_EXT);
        end else begin
          cur_d = top_pm;
          pm_d[top_pm] = 1'b0;
        end
      end
    end else if (exc_valid_i && st_q == ST_OFF) begin
      halt_d = 1'b1;
    end else if (take_o) begin
      st_d  = ST_SERVE;
      cur_d = vec_o;
      if (st_q == ST_SERVE) pm_d[cur_q] = 1'b1;
      else                  pm_d = '0;
    end else if (eint_i && st_q == ST_OFF) begin
      st_d = ST_ON;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OFF; cur_q <= '0; pm_q <= '0; halt_q <= 1'b0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; pm_q <= pm_d; halt_q <= halt_d;
    end
  end

  assign state_o = st_q;
  assign cur_o   = cur_q;
  assign pmask_o = pm_q;
  assign halt_o  = halt_q;

  p_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (st_q == ST_SERVE) && (cur_q == $past(vec_o)));
  p_preempt_higher_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SERVE && take_o) |-> vec_o > cur_q);
  p_pmask_below_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SERVE) |-> (pm_q >> cur_q) == '0);
  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SERVE && exc_valid_i && !dint_i && !reti_i && exc_kind_i <= cur_q)
      |=> $stable(cur_q) && $stable(pm_q) && st_q == ST_SERVE);
  p_ret_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !dint_i && st_q == ST_SERVE && pm_q == '0) |=> st_q == ST_ON);
  p_off_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF && exc_valid_i && !dint_i && !reti_i) |=> halt_q && !$fell(halt_q));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int KW    = KIND_W,
  parameter int NK    = NUM_KINDS,
  parameter int EW    = EXT_W,
  parameter int PW    = PC_W,
  parameter int CW    = CNT_W,
  parameter int ARG_W = $clog2(EW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insn_start_i,
  input  logic             exc_valid_i,
  input  logic [KW-1:0]    exc_kind_i,
  input  logic [EW-1:0]    ext_set_i,
  input  logic             mask_we_i,
  input  logic [EW-1:0]    mask_wdata_i,
  input  logic             eint_i,
  input  logic             dint_i,
  input  logic             reti_i,
  input  logic [PW-1:0]    ret_pc_i,
  output logic             take_o,
  output logic [KW-1:0]    vector_o,
  output logic [CW+PW-1:0] entry_word_o,
  output logic [ARG_W-1:0] ext_arg_o,
  output logic             halt_o,
  output logic [1:0]       state_o,
  output logic [KW-1:0]    cur_kind_o,
  output logic [NK-1:0]    preempt_o,
  output logic [EW-1:0]    pend_o,
  output logic [EW-1:0]    mask_o
);
  irq_state_e st;
  logic ext_req, mmio_ret, sample;

  assign sample = insn_start_i && (st == ST_ON) && !exc_valid_i
                  && !dint_i && !reti_i && !eint_i;

  irq_ext_arb #(.EXT_W(EW), .ARG_W(ARG_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (ext_set_i),
    .mask_we_i  (mask_we_i),
    .mask_wd_i  (mask_wdata_i),
    .mask_clr_i (dint_i),
    .pend_clr_i (dint_i || mmio_ret),
    .sample_i   (sample),
    .req_o      (ext_req),
    .arg_o      (ext_arg_o),
    .pend_o     (pend_o),
    .mask_o     (mask_o)
  );

  irq_prio_fsm #(.KW(KW), .NK(NK)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_valid_i (exc_valid_i),
    .exc_kind_i  (exc_kind_i),
    .ext_req_i   (ext_req),
    .eint_i      (eint_i),
    .dint_i      (dint_i),
    .reti_i      (reti_i),
    .take_o      (take_o),
    .vec_o       (vector_o),
    .mmio_ret_o  (mmio_ret),
    .halt_o      (halt_o),
    .state_o     (st),
    .cur_o       (cur_kind_o),
    .pmask_o     (preempt_o)
  );

  assign state_o      = st;
  assign entry_word_o = {push_cnt(vector_o), ret_pc_i};

  p_mmio_ret_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !dint_i && st == ST_SERVE && cur_kind_o == KIND_EXT)
      |=> pend_o == '0 && state_o == 2'd1);
  p_ext_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !exc_valid_i) |-> insn_start_i && $past(state_o) == 2'd1 || state_o == 2'd1);
endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ist, exv, mwe, ein, din, ret;
  logic [2:0] exk;
  logic [3:0] es, mwd;
  logic [27:0] pc;
  logic take;
  logic [2:0] vec, cur;
  logic [31:0] ew;
  logic [1:0] arg, st;
  logic halt;
  logic [6:0] pm;
  logic [3:0] pend, msk;

  irq_nest_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .insn_start_i(ist), .exc_valid_i(exv),
    .exc_kind_i(exk), .ext_set_i(es), .mask_we_i(mwe), .mask_wdata_i(mwd),
    .eint_i(ein), .dint_i(din), .reti_i(ret), .ret_pc_i(pc), .take_o(take),
    .vector_o(vec), .entry_word_o(ew), .ext_arg_o(arg), .halt_o(halt),
    .state_o(st), .cur_kind_o(cur), .preempt_o(pm), .pend_o(pend), .mask_o(msk));

  int n_chk = 0, n_err = 0, cyc = 0;
  int m_st, m_cur, m_pm, m_pend, m_mask, m_halt;
  string m_tag;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int hi_bit(input int v);
    int r = 0;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int pcnt(input int k);
    case (k)
      1: return 1; 3: return 2; 4: return 3; 5: return 3; 6: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic check_regs();
    chk(st == 2'(m_st), m_tag, "state", st, m_st);
    chk(halt == m_halt[0], m_tag, "halt", halt, m_halt);
    chk(pend == 4'(m_pend), m_tag, "pending", pend, m_pend);
    chk(msk == 4'(m_mask), m_tag, "mask", msk, m_mask);
    if (m_st == 2) begin
      chk(cur == 3'(m_cur), m_tag, "current kind", cur, m_cur);
      chk(pm == 7'(m_pm), m_tag, "preempt mask", pm, m_pm);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {ist, exv, mwe, ein, din, ret} = '0;
    exk = '0; es = '0; mwd = '0; pc = '0;
    repeat (2) @(negedge clk);
    m_st = 0; m_cur = 0; m_pm = 0; m_pend = 0; m_mask = 0; m_halt = 0;
    m_tag = "R11";
    rst_n = 1'b1;
  endtask

  task automatic step(input bit i_ist, input bit i_exv, input int i_exk, input int i_es,
                      input bit i_mwe, input int i_mwd, input bit i_ein, input bit i_din,
                      input bit i_ret);
    bit e_take;
    int e_vec, n_pend, n_mask, nev;
    @(negedge clk);
    check_regs();
    ist = i_ist; exv = i_exv; exk = 3'(i_exk); es = 4'(i_es); mwe = i_mwe;
    mwd = 4'(i_mwd); ein = i_ein; din = i_din; ret = i_ret; pc = 28'($urandom);
    #1;
    nev = int'(i_din) + int'(i_ret) + int'(i_exv) + int'(i_ein);
    e_take = 0; e_vec = 0;
    n_pend = m_pend | i_es;
    n_mask = i_mwe ? i_mwd : m_mask;
    if (i_din) begin
      m_tag = "R10"; m_st = 0; n_mask = 0; n_pend = 0;
    end else if (i_ret) begin
      m_tag = "R5";
      if (m_st == 2) begin
        if (m_cur == 1 || m_pm == 0) begin
          if (m_cur == 1) begin n_pend = 0; m_tag = "R6"; end
          m_st = 1; m_pm = 0;
        end else begin
          m_cur = hi_bit(m_pm); m_pm = m_pm & ~(1 << m_cur);
        end
      end
    end else if (i_exv) begin
      if (m_st == 0) begin m_tag = "R7"; m_halt = 1; end
      else if (m_st == 1) begin
        m_tag = "R2"; e_take = 1; e_vec = i_exk; m_st = 2; m_cur = i_exk; m_pm = 0;
      end else if (i_exk > m_cur) begin
        m_tag = "R3"; e_take = 1; e_vec = i_exk; m_pm = m_pm | (1 << m_cur); m_cur = i_exk;
      end else m_tag = "R4";
    end else if (i_ein) begin
      m_tag = "R10"; if (m_st == 0) m_st = 1;
    end else if (i_ist && m_st == 1 && m_pend != 0) begin
      if ((m_pend & ~m_mask & 15) != 0) begin m_tag = "R9"; n_pend = 0; end
      else begin
        m_tag = "R8"; e_take = 1; e_vec = 1; m_st = 2; m_cur = 1; m_pm = 0;
        chk(arg == 2'(hi_bit(m_pend)), "R8", "ext arg", arg, hi_bit(m_pend));
      end
    end else m_tag = "R8";
    if (nev > 1) m_tag = "R12";
    chk(take == e_take, m_tag, "take", take, e_take);
    if (e_take) begin
      chk(vec == 3'(e_vec), "R1", "vector", vec, e_vec);
      chk(ew == {4'(pcnt(e_vec)), pc}, "R1", "entry word", ew, {4'(pcnt(e_vec)), pc});
    end
    m_pend = n_pend; m_mask = n_mask;
  endtask

  initial begin
    void'($urandom(32'h5eed_1a7e));
    do_reset();
    // nest 3 -> 5, drop 4 and 5, unwind
    step(0,0,0,0, 1,15, 1,0,0);
    step(1,1,3,0, 0,0, 0,0,0);
    step(1,1,5,0, 0,0, 0,0,0);
    step(1,1,4,0, 0,0, 0,0,0);
    step(1,1,5,0, 0,0, 0,0,0);
    step(1,1,6,0, 0,0, 0,0,0);
    step(1,0,0,0, 0,0, 0,0,1);
    step(1,0,0,0, 0,0, 0,0,1);
    step(1,0,0,0, 0,0, 0,0,1);
    // external with bits 0 and 2, then preempted by a trap
    step(0,0,0,5, 0,0, 0,0,0);
    step(0,0,0,0, 0,0, 0,0,0);
    step(1,0,0,0, 0,0, 0,0,0);
    step(1,1,2,8, 0,0, 0,0,0);
    step(1,1,6,0, 0,0, 0,0,0);
    step(1,0,0,0, 0,0, 0,0,1);
    step(1,0,0,0, 0,0, 0,0,1);
    step(1,0,0,0, 0,0, 0,0,1);
    // pending bit outside mask discards everything
    step(0,0,0,0, 1,1, 0,0,0);
    step(0,0,0,6, 0,0, 0,0,0);
    step(1,0,0,0, 0,0, 0,0,0);
    step(1,0,0,1, 1,15, 0,0,0);
    step(1,0,0,0, 0,0, 0,0,0);
    step(1,0,0,0, 0,0, 0,0,1);
    // same-cycle events, disable wins; eint no effect while armed
    step(1,1,4,3, 1,15, 1,1,1);
    step(1,1,2,0, 1,15, 1,0,1);
    step(1,0,0,0, 0,0, 1,0,0);
    step(1,1,3,2, 0,0, 1,0,0);
    step(1,0,0,0, 0,0, 0,1,0);
    step(1,1,2,0, 0,0, 0,0,0);
    step(1,0,0,0, 0,0, 1,0,0);
    step(1,1,6,0, 0,0, 0,0,0);
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      bit r_ist, r_exv, r_ein, r_din, r_ret, r_mwe;
      int r_es, r_mwd;
      r_ist = ($urandom % 2) == 0;
      r_exv = (m_st == 0) ? ($urandom % 100) < 2 : ($urandom % 100) < 18;
      r_ein = (m_st == 0) ? ($urandom % 100) < 40 : ($urandom % 100) < 3;
      r_din = ($urandom % 100) < 2;
      r_ret = ($urandom % 100) < 14;
      r_mwe = ($urandom % 100) < 5;
      r_mwd = (($urandom % 4) == 0) ? int'($urandom % 16) : 15;
      r_es  = (($urandom % 100) < 12) ? int'($urandom % 16) : 0;
      step(r_ist, r_exv, 2 + int'($urandom % 5), r_es, r_mwe, r_mwd, r_ein, r_din, r_ret);
      if (m_halt != 0) begin
        step(0,0,0,0, 0,0, 0,0,0);
        do_reset();
      end
    end
    step(0,0,0,0, 0,0, 0,0,0);
    @(negedge clk);
    check_regs();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule